// File: doc/BRIEF.md
# Programmable Periodic Event Generator

This block produces a periodic event from a 32768 Hz tick enable that is sampled in a faster system clock domain. A 4-bit rate code chooses the period, which is a power of two in ticks. A free-running tick counter supplies the timing, and an event fires each time that counter reaches an exact multiple of the selected period. Event times therefore stay on a fixed grid, whatever the history of the rate code.

Each event produces a one-cycle pulse that the surrounding logic uses to set its periodic status bit. The block also gives two qualified copies of that pulse. The interrupt-request strobe is present only while interrupts are enabled. The square-wave strobe is present only while square-wave output is enabled. The square-wave output is a pulse per event, not a 50% duty waveform. The status register, the interrupt combiner and the host bus sit outside this block and take these strobes.

Top module: `ppg_top`

## Requirements
- R1: While reset is high, and on the first cycle after it, all three outputs are low. The tick counter restarts from zero.
- R2: Rate code 0 produces no events, whatever the enables.
- R3: The generator runs only when the interrupt enable is high, or when the square-wave enable is high and the square-wave output is built in (parameter HAS_SQW=1). Otherwise it produces no events.
- R4: Rate code 1 gives the same event times as code 8, and rate code 2 gives the same event times as code 9.
- R5: For rate codes 3 to 15, the period is 2^(code-1) ticks. For example, code 3 gives 4 ticks and code 15 gives 16384 ticks.
- R6: The tick counter is 15 bits wide and wraps. It increments once per cycle in which tick_en_i is high. An event fires when the counter value after that increment is a multiple of the period, so events sit on absolute multiples of the period.
- R7: Each event gives a single-cycle pulse on per_flag_o. The pulse appears in the cycle after the clock edge that sampled the tick which caused it.
- R8: irq_o pulses together with per_flag_o only when irq_en_i was high on the tick that caused the event.
- R9: sqw_o pulses together with per_flag_o only when sqw_en_i was high on the tick that caused the event.
- R10: A new rate code takes effect at the next multiple of the new period. The tick counter is not reset when the code changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en_i | input | 1 | One-cycle enable at 32768 Hz |
| rate_code_i | input | 4 | Rate select code |
| irq_en_i | input | 1 | Periodic interrupt enable |
| sqw_en_i | input | 1 | Square-wave pulse enable |
| per_flag_o | output | 1 | Event pulse that sets the periodic status bit |
| irq_o | output | 1 | Event pulse qualified by the interrupt enable |
| sqw_o | output | 1 | Event pulse qualified by the square-wave enable |

## Verification
Directed runs check the period of every code from the shortest to the longest. In these runs the tick enable is high on every cycle, which isolates the period arithmetic. Further runs compare codes 1 and 2 against codes 8 and 9, which separates the aliasing from a straight linear decode. Other directed runs switch the rate code in mid-count; this shows whether the events stay on absolute multiples of the period or drift to "last event plus period". Random runs thin the tick enable and flip both enables and code 0 at random. These runs show whether the gating conditions stop events and whether the qualified strobes follow the enable that was sampled on the tick.

// File: rtl/ppg_pkg.sv
package ppg_pkg;
  localparam int CODE_W = 4;

  // Codes 1 and 2 alias onto the slower codes 8 and 9.
  function automatic logic [CODE_W-1:0] eff_code(input logic [CODE_W-1:0] c);
    logic [CODE_W-1:0] r;
    if (c == CODE_W'(1))      r = CODE_W'(8);
    else if (c == CODE_W'(2)) r = CODE_W'(9);
    else                      r = c;
    return r;
  endfunction
endpackage

// File: rtl/ppg_rate_decode.sv
module ppg_rate_decode
  import ppg_pkg::*;
#(
  parameter int CNT_W = 15
) (
  input  logic [CODE_W-1:0] code_i,
  output logic              active_o,
  output logic [CNT_W-1:0]  mask_o
);
  logic [CODE_W-1:0] eff;

  always_comb begin
    eff      = eff_code(code_i);
    active_o = (code_i != '0);
    // The mask covers the bits below the period's bit position (eff-1).
    for (int i = 0; i < CNT_W; i++) begin
      mask_o[i] = (i < (int'(eff) - 1));
    end
  end
endmodule

// File: rtl/ppg_tick_counter.sv
module ppg_tick_counter #(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_next_o
);
  logic [CNT_W-1:0] cnt_q;

  assign cnt_next_o = cnt_q + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst)         cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_next_o;
  end

  // R6: the counter advances by exactly one on each tick
  p_count_step_r6: assert property (@(posedge clk) disable iff (rst)
    tick_i |=> (cnt_q == $past(cnt_next_o)));
endmodule

// File: rtl/ppg_event_unit.sv
module ppg_event_unit #(
  parameter bit HAS_SQW = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic hit_i,
  input  logic irq_en_i,
  input  logic sqw_en_i,
  output logic flag_o,
  output logic irq_o,
  output logic sqw_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flag_o <= 1'b0;
      irq_o  <= 1'b0;
    end else begin
      flag_o <= hit_i;
      irq_o  <= hit_i & irq_en_i;
    end
  end

  generate
    if (HAS_SQW) begin : g_sqw
      always_ff @(posedge clk) begin
        if (rst) sqw_o <= 1'b0;
        else     sqw_o <= hit_i & sqw_en_i;
      end
    end else begin : g_nosqw
      assign sqw_o = 1'b0;
    end
  endgenerate

  // R8: an interrupt strobe never appears without the event pulse
  p_irq_with_flag_r8: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> flag_o);
  // R9: a square-wave strobe never appears without the event pulse
  p_sqw_with_flag_r9: assert property (@(posedge clk) disable iff (rst)
    sqw_o |-> flag_o);
endmodule

// File: rtl/ppg_top.sv
module ppg_top
  import ppg_pkg::*;
#(
  parameter int CNT_W   = 15,
  parameter bit HAS_SQW = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en_i,
  input  logic [CODE_W-1:0] rate_code_i,
  input  logic              irq_en_i,
  input  logic              sqw_en_i,
  output logic              per_flag_o,
  output logic              irq_o,
  output logic              sqw_o
);
  logic             active;
  logic [CNT_W-1:0] mask;
  logic [CNT_W-1:0] cnt_next;
  logic             run;
  logic             hit;

  ppg_rate_decode #(.CNT_W(CNT_W)) u_dec (
    .code_i   (rate_code_i),
    .active_o (active),
    .mask_o   (mask)
  );

  ppg_tick_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .tick_i     (tick_en_i),
    .cnt_next_o (cnt_next)
  );

  assign run = active & (irq_en_i | (sqw_en_i & HAS_SQW));
  assign hit = tick_en_i & run & ((cnt_next & mask) == '0);

  ppg_event_unit #(.HAS_SQW(HAS_SQW)) u_evt (
    .clk      (clk),
    .rst      (rst),
    .hit_i    (hit),
    .irq_en_i (irq_en_i),
    .sqw_en_i (sqw_en_i),
    .flag_o   (per_flag_o),
    .irq_o    (irq_o),
    .sqw_o    (sqw_o)
  );

  // R2: code 0 gives no event on the following cycle
  p_zero_code_silent_r2: assert property (@(posedge clk) disable iff (rst)
    (rate_code_i == '0) |=> !per_flag_o);
  // R3: with neither enable high, no event follows
  p_stopped_silent_r3: assert property (@(posedge clk) disable iff (rst)
    (!irq_en_i && !sqw_en_i) |=> !per_flag_o);
  // R7: the event pulse lasts a single cycle
  p_flag_single_r7: assert property (@(posedge clk) disable iff (rst)
    per_flag_o |=> !per_flag_o);
  // R6: an event follows only a sampled tick
  p_flag_after_tick_r6: assert property (@(posedge clk) disable iff (rst)
    per_flag_o |-> $past(tick_en_i));
endmodule

// File: tb/tb_ppg_top.sv
module tb_ppg_top;
  logic       clk = 1'b0;
  logic       rst;
  logic       tick_en_i;
  logic [3:0] rate_code_i;
  logic       irq_en_i;
  logic       sqw_en_i;
  logic       per_flag_o;
  logic       irq_o;
  logic       sqw_o;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  logic [14:0] cnt_m;
  logic        e_flag, e_irq, e_sqw;
  string       phase_tag;

  always #2 clk = ~clk;

  ppg_top dut (
    .clk(clk), .rst(rst), .tick_en_i(tick_en_i), .rate_code_i(rate_code_i),
    .irq_en_i(irq_en_i), .sqw_en_i(sqw_en_i),
    .per_flag_o(per_flag_o), .irq_o(irq_o), .sqw_o(sqw_o)
  );

  // Period per R4/R5: codes 1,2 -> 8,9; period = 2^(code-1) ticks
  function automatic int period_of(input logic [3:0] c);
    int e;
    e = (c == 4'd1) ? 8 : (c == 4'd2) ? 9 : int'(c);
    return 1 << (e - 1);
  endfunction

  function automatic string tag_of(input logic r, input logic [3:0] c,
                                   input logic p, input logic s);
    if (r)                return "R1";
    if (phase_tag != "")  return phase_tag;
    if (c == 4'd0)        return "R2";
    if (!p && !s)         return "R3";
    if (c <= 4'd2)        return "R4";
    return "R6";
  endfunction

  task automatic step(input logic t, input logic [3:0] c,
                      input logic p, input logic s, input logic r);
    logic  ev;
    string tg;
    tick_en_i = t; rate_code_i = c; irq_en_i = p; sqw_en_i = s; rst = r;
    tg = tag_of(r, c, p, s);
    if (r) begin
      cnt_m = '0; e_flag = 0; e_irq = 0; e_sqw = 0;
    end else begin
      if (t) cnt_m = cnt_m + 15'd1;
      // R6/R7: event when the new count is a multiple of the period
      ev = t && (c != 0) && (p || s) &&
           ((int'(cnt_m) % period_of(c)) == 0);
      e_flag = ev; e_irq = ev && p; e_sqw = ev && s;
    end
    @(negedge clk);
    vectors++;
    if (per_flag_o !== e_flag) begin
      errors++;
      $display("FAIL %s per_flag_o got %b exp %b (code %0d)", tg, per_flag_o, e_flag, c);
    end
    if (irq_o !== e_irq) begin
      errors++;
      $display("FAIL R8 %s irq_o got %b exp %b", tg, irq_o, e_irq);
    end
    if (sqw_o !== e_sqw) begin
      errors++;
      $display("FAIL R9 %s sqw_o got %b exp %b", tg, sqw_o, e_sqw);
    end
  endtask

  task automatic run(input int n, input logic [3:0] c,
                     input logic p, input logic s);
    for (int i = 0; i < n; i++) step(1'b1, c, p, s, 1'b0);
  endtask

  initial begin
    int unsigned seed_init;
    seed_init = $urandom(32'd4242);
    phase_tag = "";
    cnt_m = '0;
    tick_en_i = 0; rate_code_i = 0; irq_en_i = 0; sqw_en_i = 0; rst = 1;
    @(negedge clk);
    // R1: reset held with everything enabled
    for (int i = 0; i < 4; i++) step(1'b1, 4'd3, 1'b1, 1'b1, 1'b1);
    // R2: code 0 with both enables on
    run(300, 4'd0, 1'b1, 1'b1);
    // R3: valid code, both enables off
    run(300, 4'd3, 1'b0, 1'b0);
    // R5: every code 3..15, ticking every cycle
    phase_tag = "R5";
    for (int c = 3; c <= 15; c++) run(period_of(4'(c)) * 2 + 3, 4'(c), 1'b1, 1'b0);
    // R4: aliased codes against their targets
    phase_tag = "R4";
    run(600, 4'd1, 1'b1, 1'b1);
    run(600, 4'd8, 1'b0, 1'b1);
    run(1100, 4'd2, 1'b1, 1'b0);
    run(1100, 4'd9, 1'b1, 1'b1);
    // R10: switch codes in mid-count; grid must stay absolute
    phase_tag = "R10";
    for (int k = 0; k < 20; k++) begin
      run(5 + k * 7, 4'(3 + (k % 5)), 1'b1, 1'b1);
    end
    // R8/R9: square-wave only, then interrupt only
    phase_tag = "R9";
    run(200, 4'd4, 1'b0, 1'b1);
    phase_tag = "R8";
    run(200, 4'd4, 1'b1, 1'b0);
    // R1: mid-run reset restarts the counter
    phase_tag = "";
    for (int i = 0; i < 3; i++) step(1'b1, 4'd4, 1'b1, 1'b1, 1'b1);
    run(100, 4'd4, 1'b1, 1'b1);
    // Random mix
    for (int blk = 0; blk < 150; blk++) begin
      logic [3:0] c;
      logic p, s;
      int   w;
      w = $urandom_range(0, 9);
      c = (w < 6) ? 4'($urandom_range(3, 7)) :
          (w < 8) ? 4'($urandom_range(0, 2)) : 4'($urandom_range(8, 10));
      p = 1'($urandom_range(0, 1));
      s = 1'($urandom_range(0, 1));
      for (int i = 0; i < 120; i++)
        step(($urandom_range(0, 3) != 0), c, p, s, 1'b0);
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule